// File: doc/BRIEF.md
# Condition Register Logic Unit

A purely combinational execution stage for instructions that work on the 32-bit condition register (CR). The CR is made of eight 4-bit fields. Field 0 is the most significant nibble, and bit 0 is the most significant bit. The unit supports five operations:

- an integer select that picks one of two 64-bit operands using one bit of an incoming CR field;
- a boolean combine of two CR bits, controlled by a 4-bit truth table;
- a copy of one CR field to another;
- a masked move from operand A into the CR;
- a move of the CR into the 64-bit result.

Decode, register file access and pipeline handshaking are outside the unit. The surrounding pipeline presents the operation code, the operands and the decoded instruction fields. It takes whichever of the three results the operation produces in the same cycle.

Top module: `cr_logic_unit`

## Requirements
- R1: CR field i occupies bits (7-i)*4+3 down to (7-i)*4 of the 32-bit CR, and CR bit n is CR[31-n], so index 0 is always the most significant end. Every operation below uses this numbering.
- R2: For op_i=1 (select), index k = sel_bc_i[1:0] picks bit 3-k of cr_field_i. result_o is opa_i when that bit is 1 and opb_i when it is 0. cr_field_o and cr_full_o are 0.
- R3: For op_i=1, sel_bc_i[4:2] has no effect on any output.
- R4: For op_i=2 (bit combine), the new bit is lut_i[{CR bit bit_a_idx_i, CR bit bit_b_idx_i}], where the first bit is the MSB of the index. The new bit is written to CR bit bit_t_idx_i. As examples, lut 1000 gives AND, 1110 gives OR, 0110 gives XOR and 0001 gives NOR.
- R5: For op_i=2, cr_full_o equals cr_full_i except for the one target bit, and cr_field_o equals the updated field bit_t_idx_i[4:2]. result_o is 0.
- R6: For op_i=3 (field copy), cr_field_o is field fld_src_i of cr_full_i. cr_full_o is cr_full_i with field fld_dst_i replaced by that value. result_o is 0.
- R7: For op_i=4 (move to CR), field j of cr_full_o takes opa_i[(7-j)*4+3:(7-j)*4] when fld_mask_i[7-j] is 1. Otherwise it keeps field j of cr_full_i. result_o and cr_field_o are 0.
- R8: For op_i=5 (move from CR), result_o is cr_full_i zero-extended to 64 bits, cr_full_o equals cr_full_i, and cr_field_o is 0.
- R9: Op codes 0, 6 and 7 drive all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (1 select, 2 bit combine, 3 field copy, 4 move to CR, 5 move from CR) |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| cr_field_i | input | 4 | CR field addressed by the select operation |
| cr_full_i | input | 32 | Full condition register |
| sel_bc_i | input | 5 | Select condition bit field; low 2 bits used |
| bit_a_idx_i | input | 5 | First source CR bit for bit combine |
| bit_b_idx_i | input | 5 | Second source CR bit for bit combine |
| bit_t_idx_i | input | 5 | Target CR bit for bit combine |
| lut_i | input | 4 | Truth table for bit combine |
| fld_src_i | input | 3 | Source field for field copy |
| fld_dst_i | input | 3 | Destination field for field copy |
| fld_mask_i | input | 8 | Field enable mask for move to CR, bit 7 = field 0 |
| result_o | output | 64 | 64-bit result |
| cr_field_o | output | 4 | 4-bit CR field result |
| cr_full_o | output | 32 | 32-bit full CR result |

## Verification
The bound checker evaluates structural properties whenever the inputs change:

- the select result is always one of its two operands and follows the chosen CR bit;
- a bit combine changes at most one CR bit, and its field output matches the target field of the full output;
- a copy leaves the destination field equal to the field output;
- an all-zero mask leaves the CR untouched, and move from CR leaves the upper half of the result zero;
- unused outputs and unused op codes give zeros.

The exact bit ordering (which index maps to which bit or field), every truth-table entry, and the nibble chosen per mask bit are shown only by the bench's directed and random scenarios against its independent model.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned N_FIELDS = 8;
  localparam int unsigned CR_W     = FIELD_W * N_FIELDS;
  localparam int unsigned FB_W     = $clog2(FIELD_W);
  localparam int unsigned FI_W     = $clog2(N_FIELDS);
  localparam int unsigned BI_W     = $clog2(CR_W);

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SEL  = 3'd1,
    OP_BOOL = 3'd2,
    OP_COPY = 3'd3,
    OP_MTCR = 3'd4,
    OP_MFCR = 3'd5
  } cr_op_e;
endpackage

// File: rtl/cr_isel.sv
module cr_isel #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned FB_W   = $clog2(FIELD_W)
) (
  input  logic [FB_W-1:0]    sel_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [DATA_W-1:0]  res_o
);
  // msb-first view of the field
  logic [FIELD_W-1:0] rev;
  for (genvar k = 0; k < FIELD_W; k++) begin : g_rev
    assign rev[k] = field_i[FIELD_W-1-k];
  end
  assign res_o = rev[sel_i] ? a_i : b_i;
endmodule

// File: rtl/cr_bitop.sv
module cr_bitop #(
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned N_FIELDS = 8,
  localparam int unsigned CR_W    = FIELD_W * N_FIELDS,
  localparam int unsigned FB_W    = $clog2(FIELD_W),
  localparam int unsigned FI_W    = $clog2(N_FIELDS),
  localparam int unsigned BI_W    = $clog2(CR_W)
) (
  input  logic [CR_W-1:0]    cr_i,
  input  logic [BI_W-1:0]    ba_i,
  input  logic [BI_W-1:0]    bb_i,
  input  logic [BI_W-1:0]    bt_i,
  input  logic [3:0]         lut_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [CR_W-1:0]    full_o
);
  logic [CR_W-1:0]    rev;
  logic [FIELD_W-1:0] fld [N_FIELDS];
  logic [FIELD_W-1:0] new_fld;
  logic [FI_W-1:0]    tgt;
  logic [FB_W-1:0]    pos;
  logic               va, vb, nv;

  for (genvar n = 0; n < CR_W; n++) begin : g_rev
    assign rev[n] = cr_i[CR_W-1-n];
  end
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    assign fld[i] = cr_i[(N_FIELDS-1-i)*FIELD_W +: FIELD_W];
  end

  assign va  = rev[ba_i];
  assign vb  = rev[bb_i];
  assign nv  = lut_i[{va, vb}];
  assign tgt = bt_i[BI_W-1:FB_W];
  assign pos = bt_i[FB_W-1:0];

  always_comb begin
    new_fld = fld[tgt];
    for (int k = 0; k < FIELD_W; k++) begin
      if (pos == FB_W'(k)) new_fld[FIELD_W-1-k] = nv;
    end
  end

  assign field_o = new_fld;
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_out
    assign full_o[(N_FIELDS-1-i)*FIELD_W +: FIELD_W] =
      (tgt == FI_W'(i)) ? new_fld : fld[i];
  end
endmodule

// File: rtl/cr_fieldcopy.sv
module cr_fieldcopy #(
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned N_FIELDS = 8,
  localparam int unsigned CR_W    = FIELD_W * N_FIELDS,
  localparam int unsigned FI_W    = $clog2(N_FIELDS)
) (
  input  logic [CR_W-1:0]    cr_i,
  input  logic [FI_W-1:0]    src_i,
  input  logic [FI_W-1:0]    dst_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [CR_W-1:0]    full_o
);
  logic [FIELD_W-1:0] fld [N_FIELDS];
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    assign fld[i] = cr_i[(N_FIELDS-1-i)*FIELD_W +: FIELD_W];
  end
  assign field_o = fld[src_i];
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_out
    assign full_o[(N_FIELDS-1-i)*FIELD_W +: FIELD_W] =
      (dst_i == FI_W'(i)) ? field_o : fld[i];
  end
endmodule

// File: rtl/cr_mtcr.sv
module cr_mtcr #(
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned N_FIELDS = 8,
  localparam int unsigned CR_W    = FIELD_W * N_FIELDS
) (
  input  logic [CR_W-1:0]     cr_i,
  input  logic [CR_W-1:0]     src_i,
  input  logic [N_FIELDS-1:0] mask_i,
  output logic [CR_W-1:0]     full_o
);
  // mask bit j from msb enables field j
  for (genvar j = 0; j < N_FIELDS; j++) begin : g_fld
    localparam int unsigned LSB = (N_FIELDS-1-j) * FIELD_W;
    assign full_o[LSB +: FIELD_W] = mask_i[N_FIELDS-1-j] ?
      src_i[LSB +: FIELD_W] : cr_i[LSB +: FIELD_W];
  end
endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit
  import cr_pkg::*;
(
  input  logic [2:0]          op_i,
  input  logic [DATA_W-1:0]   opa_i,
  input  logic [DATA_W-1:0]   opb_i,
  input  logic [FIELD_W-1:0]  cr_field_i,
  input  logic [CR_W-1:0]     cr_full_i,
  input  logic [BI_W-1:0]     sel_bc_i,
  input  logic [BI_W-1:0]     bit_a_idx_i,
  input  logic [BI_W-1:0]     bit_b_idx_i,
  input  logic [BI_W-1:0]     bit_t_idx_i,
  input  logic [3:0]          lut_i,
  input  logic [FI_W-1:0]     fld_src_i,
  input  logic [FI_W-1:0]     fld_dst_i,
  input  logic [N_FIELDS-1:0] fld_mask_i,
  output logic [DATA_W-1:0]   result_o,
  output logic [FIELD_W-1:0]  cr_field_o,
  output logic [CR_W-1:0]     cr_full_o
);
  logic [DATA_W-1:0]  sel_res;
  logic [FIELD_W-1:0] bool_fld, copy_fld;
  logic [CR_W-1:0]    bool_cr, copy_cr, mtcr_cr;

  cr_isel #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_isel (
    .sel_i   (sel_bc_i[FB_W-1:0]),
    .field_i (cr_field_i),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .res_o   (sel_res)
  );

  cr_bitop #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_bitop (
    .cr_i    (cr_full_i),
    .ba_i    (bit_a_idx_i),
    .bb_i    (bit_b_idx_i),
    .bt_i    (bit_t_idx_i),
    .lut_i   (lut_i),
    .field_o (bool_fld),
    .full_o  (bool_cr)
  );

  cr_fieldcopy #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_copy (
    .cr_i    (cr_full_i),
    .src_i   (fld_src_i),
    .dst_i   (fld_dst_i),
    .field_o (copy_fld),
    .full_o  (copy_cr)
  );

  cr_mtcr #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_mtcr (
    .cr_i   (cr_full_i),
    .src_i  (opa_i[CR_W-1:0]),
    .mask_i (fld_mask_i),
    .full_o (mtcr_cr)
  );

  always_comb begin
    result_o   = '0;
    cr_field_o = '0;
    cr_full_o  = '0;
    case (op_i)
      OP_SEL:  result_o = sel_res;
      OP_BOOL: begin
        cr_field_o = bool_fld;
        cr_full_o  = bool_cr;
      end
      OP_COPY: begin
        cr_field_o = copy_fld;
        cr_full_o  = copy_cr;
      end
      OP_MTCR: cr_full_o = mtcr_cr;
      OP_MFCR: begin
        result_o  = {{(DATA_W-CR_W){1'b0}}, cr_full_i};
        cr_full_o = cr_full_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cr_logic_unit_chk.sv
module cr_logic_unit_chk
  import cr_pkg::*;
(
  input logic [2:0]          op_i,
  input logic [DATA_W-1:0]   opa_i,
  input logic [DATA_W-1:0]   opb_i,
  input logic [FIELD_W-1:0]  cr_field_i,
  input logic [CR_W-1:0]     cr_full_i,
  input logic [BI_W-1:0]     sel_bc_i,
  input logic [BI_W-1:0]     bit_a_idx_i,
  input logic [BI_W-1:0]     bit_b_idx_i,
  input logic [BI_W-1:0]     bit_t_idx_i,
  input logic [3:0]          lut_i,
  input logic [FI_W-1:0]     fld_src_i,
  input logic [FI_W-1:0]     fld_dst_i,
  input logic [N_FIELDS-1:0] fld_mask_i,
  input logic [DATA_W-1:0]   result_o,
  input logic [FIELD_W-1:0]  cr_field_o,
  input logic [CR_W-1:0]     cr_full_o
);
  logic [FIELD_W-1:0] tgt_out, dst_out;
  always_comb begin
    tgt_out = '0;
    dst_out = '0;
    for (int i = 0; i < N_FIELDS; i++) begin
      if (bit_t_idx_i[BI_W-1:FB_W] == FI_W'(i))
        tgt_out = cr_full_o[(N_FIELDS-1-i)*FIELD_W +: FIELD_W];
      if (fld_dst_i == FI_W'(i))
        dst_out = cr_full_o[(N_FIELDS-1-i)*FIELD_W +: FIELD_W];
    end
  end

  logic unused_ok;
  assign unused_ok = ^{bit_a_idx_i, bit_b_idx_i, lut_i, fld_src_i, sel_bc_i, cr_field_i};

  always_comb begin
    if (op_i == OP_SEL) begin
      a_r2_sel_operand: assert (result_o == opa_i || result_o == opb_i)
        else $error("R2 select result is neither operand");
      a_r2_sel_zero: assert (cr_full_o == '0 && cr_field_o == '0)
        else $error("R2 select drives CR outputs");
    end
    if (op_i == OP_BOOL) begin
      a_r5_bool_onebit: assert ($countones(cr_full_o ^ cr_full_i) <= 1 && result_o == '0)
        else $error("R5 bit combine changed more than one bit");
      a_r5_bool_field: assert (cr_field_o == tgt_out)
        else $error("R5 field output differs from target field");
    end
    if (op_i == OP_COPY) begin
      a_r6_copy_dst: assert (dst_out == cr_field_o && result_o == '0)
        else $error("R6 destination field mismatch");
    end
    if (op_i == OP_MTCR && fld_mask_i == '0) begin
      a_r7_mtcr_nomask: assert (cr_full_o == cr_full_i)
        else $error("R7 empty mask changed CR");
    end
    if (op_i == OP_MFCR) begin
      a_r8_mfcr_upper: assert (result_o[DATA_W-1:CR_W] == '0 && cr_field_o == '0)
        else $error("R8 upper result bits set");
    end
    if (op_i == OP_NONE || op_i > OP_MFCR) begin
      a_r9_idle_zero: assert (result_o == '0 && cr_field_o == '0 && cr_full_o == '0)
        else $error("R9 unused op code drives outputs");
    end
  end
endmodule

bind cr_logic_unit cr_logic_unit_chk u_chk (.*);

// File: tb/sim_cr_logic_unit.sv
module sim_cr_logic_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]  op;
  logic [63:0] opa, opb, res;
  logic [3:0]  cfi, cfo, lut;
  logic [31:0] cri, cro;
  logic [4:0]  bc, ba, bb, bt;
  logic [2:0]  src, dst;
  logic [7:0]  mask;

  cr_logic_unit u0 (
    .op_i(op), .opa_i(opa), .opb_i(opb), .cr_field_i(cfi), .cr_full_i(cri),
    .sel_bc_i(bc), .bit_a_idx_i(ba), .bit_b_idx_i(bb), .bit_t_idx_i(bt),
    .lut_i(lut), .fld_src_i(src), .fld_dst_i(dst), .fld_mask_i(mask),
    .result_o(res), .cr_field_o(cfo), .cr_full_o(cro)
  );

  typedef struct {
    logic [63:0] res;
    logic [3:0]  fld;
    logic [31:0] full;
    string       tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  function automatic logic [3:0] m_fld(logic [31:0] c, int i);
    return c[31-4*i -: 4];
  endfunction

  function automatic exp_t model(string tag);
    exp_t e;
    logic va, vb, nv;
    e.res = '0; e.fld = '0; e.full = '0; e.tag = tag;
    case (op)
      3'd1: e.res = cfi[3 - int'(bc[1:0])] ? opa : opb;
      3'd2: begin
        va = cri[31 - int'(ba)];
        vb = cri[31 - int'(bb)];
        nv = lut[{va, vb}];
        e.full = cri;
        e.full[31 - int'(bt)] = nv;
        e.fld = m_fld(e.full, int'(bt) / 4);
      end
      3'd3: begin
        e.fld = m_fld(cri, int'(src));
        e.full = cri;
        e.full[31 - 4*int'(dst) -: 4] = e.fld;
      end
      3'd4: begin
        e.full = cri;
        for (int j = 0; j < 8; j++)
          if (mask[7-j]) e.full[31-4*j -: 4] = opa[31-4*j -: 4];
      end
      3'd5: begin
        e.res = {32'd0, cri};
        e.full = cri;
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic apply(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] cf, input logic [31:0] cr, input logic [4:0] ibc,
                       input logic [4:0] iba, input logic [4:0] ibb, input logic [4:0] ibt,
                       input logic [3:0] ilut, input logic [2:0] isrc, input logic [2:0] idst,
                       input logic [7:0] imask, input string tag);
    @(negedge clk);
    op = o; opa = a; opb = b; cfi = cf; cri = cr; bc = ibc; ba = iba; bb = ibb;
    bt = ibt; lut = ilut; src = isrc; dst = idst; mask = imask;
    q.push_back(model(tag));
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (res !== e.res || cfo !== e.fld || cro !== e.full) begin
        errors++;
        $display("FAIL %s: got res=%h fld=%h cr=%h exp res=%h fld=%h cr=%h",
                 e.tag, res, cfo, cro, e.res, e.fld, e.full);
      end
    end
  end

  logic done = 1'b0;
  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung exp finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [63:0] A = 64'hA5A5_0F0F_1234_5678;
  localparam logic [63:0] B = 64'h5A5A_F0F0_8765_4321;
  localparam logic [31:0] C = 32'h9E3C_71D2;

  initial begin
    op = '0; opa = '0; opb = '0; cfi = '0; cri = '0; bc = '0; ba = '0; bb = '0;
    bt = '0; lut = '0; src = '0; dst = '0; mask = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle state: all inputs zero
    apply(3'd0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, "R9 idle");
    // R2: one-hot CR field, every index, R1 msb-first order
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 4; f++)
        apply(3'd1, A, B, 4'b1000 >> f, C, 5'(k), 0, 0, 0, 0, 0, 0, 0, "R2 select");
    // R3: upper bits of selector ignored
    for (int u = 0; u < 8; u++)
      apply(3'd1, A, B, 4'b0100, C, 5'({u[2:0], 2'd1}), 0, 0, 0, 0, 0, 0, 0, "R3 select upper");
    // R4: every truth table on all four input pairs
    for (int l = 0; l < 16; l++)
      for (int p = 0; p < 4; p++)
        apply(3'd2, A, B, 0, 32'h8000_0001 | (p[1] ? 32'h4000_0000 : 0) | (p[0] ? 32'h2 : 0),
              0, 5'd1, 5'd30, 5'd13, 4'(l), 0, 0, 0, "R4 truth table");
    // R5: targets at field boundaries
    foreach (C[t])
      apply(3'd2, A, B, 0, C, 0, 5'd0, 5'd31, 5'(t), 4'b0110, 0, 0, 0, "R5 target sweep");
    // R6: every source/destination pair
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++)
        apply(3'd3, A, B, 0, C, 0, 0, 0, 0, 0, 3'(s), 3'(d), 0, "R6 copy");
    // R7: single-field masks, empty, full
    for (int j = 0; j < 8; j++)
      apply(3'd4, A, B, 0, C, 0, 0, 0, 0, 0, 0, 0, 8'h80 >> j, "R7 mask one");
    apply(3'd4, A, B, 0, C, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R7 mask empty");
    apply(3'd4, A, B, 0, C, 0, 0, 0, 0, 0, 0, 0, 8'hFF, "R7 mask full");
    // R8
    apply(3'd5, A, B, 4'hF, C, 5'h1F, 0, 0, 0, 0, 0, 0, 8'hFF, "R8 move from CR");
    apply(3'd5, A, B, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R8 move from CR ones");
    // R9: unused codes with busy inputs
    apply(3'd6, A, B, 4'hF, C, 5'h1F, 5'h3, 5'h7, 5'h9, 4'hF, 3'd2, 3'd5, 8'hFF, "R9 code 6");
    apply(3'd7, A, B, 4'hF, C, 5'h1F, 5'h3, 5'h7, 5'h9, 4'hF, 3'd2, 3'd5, 8'hFF, "R9 code 7");
    apply(3'd0, A, B, 4'hF, C, 5'h1F, 5'h3, 5'h7, 5'h9, 4'hF, 3'd2, 3'd5, 8'hFF, "R9 code 0");
    // random mix, R1 numbering across all ops
    for (int i = 0; i < 400; i++)
      apply(3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom},
            4'($urandom), 32'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
            5'($urandom), 4'($urandom), 3'($urandom), 3'($urandom), 8'($urandom),
            "R1 random mix");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule